// File: doc/BRIEF.md
# Masked Interrupt Aggregator

This block collects event flags from surrounding logic into two sticky 8-bit event registers, a high one and a low one. Each event register has its own mask. A third mask enables a small set of level-type summary sources. The enabled conditions are ORed together onto one active-high interrupt line. A register write port clears event bits and loads the masks. A transaction-active input frames that port, in the way a chip-select frames a serial access.

A write to either event register hides the interrupt for the rest of that transaction. Software that clears events through a serial link therefore never sees the line flicker while the clear is in progress. A two-state blanking machine handles this. In state `BLK_IDLE` the interrupt is visible. The transition *arm* (an event-register write while the transaction is not ending) enters `BLK_HOLD`, where the interrupt is forced low. The transition *release* (a falling edge of the transaction-active input) returns to `BLK_IDLE`. A separate registered link-status output follows a link bit and is cleared by a communication-fault pulse.

Top module: `irq_aggregator`

## Requirements
- R1: After reset all event and mask registers read as zero, and `irq` and `link_up` are low.
- R2: A one-cycle high on `evt_set_hi[i]` or `evt_set_lo[i]` sets that event bit at the next clock edge. The bit stays set until it is cleared.
- R3: Writing to address 0 (high events) or address 1 (low events) clears every bit where `wr_data` is 1 and leaves the other bits unchanged. If a set pulse and a clear hit the same bit in the same cycle, the bit ends up set.
- R4: A write to address 2 loads the high mask, address 3 the low mask, and address 4 the summary mask (low `SUM_W` bits). `rd_data` returns the high events, low events, high mask, low mask and summary mask at addresses 0 to 4, combinationally from `rd_addr`. Any other address reads zero and ignores writes.
- R5: Outside blanking, `irq` is high exactly when (high events AND high mask), (low events AND low mask) or (`sum_src` AND summary mask) has any bit set.
- R6: A write to address 0 or 1 enters blanking at the next edge, and `irq` stays low from then on. Blanking ends at the first clock edge that samples `xact_active` low after it was sampled high.
- R7: Writes to the mask addresses or unused addresses never start blanking.
- R8: `link_up` is `link_bit` registered. A high on `link_fault` forces `link_up` low at the next edge, whatever `link_bit` is.
- R9: An event-register write in the same cycle as the transaction's falling edge is sampled does not blank.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| evt_set_hi | input | EVT_W | Set pulses for the high event register |
| evt_set_lo | input | EVT_W | Set pulses for the low event register |
| sum_src | input | SUM_W | Level summary sources |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | ADDR_W | Write address |
| wr_data | input | EVT_W | Write data |
| xact_active | input | 1 | High while a serial transaction is in progress |
| rd_addr | input | ADDR_W | Read address |
| rd_data | output | EVT_W | Read data |
| link_bit | input | 1 | Link status source |
| link_fault | input | 1 | Communication fault pulse |
| irq | output | 1 | Interrupt output, active high |
| link_up | output | 1 | Registered link status |

## Verification
A wrong event or mask bit shows at `rd_data` as soon as its address is read. It also shows on `irq` in the first cycle where the matching mask bit is set. A blanking machine stuck in `BLK_HOLD` keeps `irq` low after a transaction ends, and the next cycle with a pending, enabled event exposes this. A machine that never arms lets `irq` through in the cycle right after an event-register write. Random traffic checks every output on every cycle, so a divergence appears within one cycle of the stimulus that provokes it.

// File: rtl/irq_agg_pkg.sv
package irq_agg_pkg;
    localparam int ADR_EVT_HI  = 0;
    localparam int ADR_EVT_LO  = 1;
    localparam int ADR_MSK_HI  = 2;
    localparam int ADR_MSK_LO  = 3;
    localparam int ADR_MSK_SUM = 4;

    typedef enum logic {
        BLK_IDLE = 1'b0,
        BLK_HOLD = 1'b1
    } blk_state_e;
endpackage

// File: rtl/irq_evt_reg.sv
module irq_evt_reg #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] set_pulse,
    input  logic         clr_en,
    input  logic [W-1:0] clr_bits,
    output logic [W-1:0] q
);
    for (genvar b = 0; b < W; b++) begin : g_bit
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                q[b] <= 1'b0;
            else if (set_pulse[b])
                q[b] <= 1'b1;
            else if (clr_en && clr_bits[b])
                q[b] <= 1'b0;
        end
    end
endmodule

// File: rtl/irq_mask_reg.sv
module irq_mask_reg #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         we,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            q <= '0;
        else if (we)
            q <= d;
    end
endmodule

// File: rtl/irq_blank_fsm.sv
module irq_blank_fsm
    import irq_agg_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic xact_active,
    input  logic evt_wr,
    output logic blanked
);
    blk_state_e state_q, state_d;
    logic       xact_d;
    logic       xact_fall;

    assign xact_fall = xact_d && !xact_active;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            xact_d <= 1'b0;
        else
            xact_d <= xact_active;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state_q <= BLK_IDLE;
        else
            state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            BLK_IDLE: if (evt_wr && !xact_fall) state_d = BLK_HOLD;  // arm
            BLK_HOLD: if (xact_fall)            state_d = BLK_IDLE;  // release
            default:                            state_d = BLK_IDLE;
        endcase
    end

    always_comb begin
        blanked = 1'b0;
        unique case (state_q)
            BLK_IDLE: blanked = 1'b0;
            BLK_HOLD: blanked = 1'b1;
            default:  blanked = 1'b0;
        endcase
    end
endmodule

// File: rtl/irq_link_track.sv
module irq_link_track (
    input  logic clk,
    input  logic rst_n,
    input  logic link_bit,
    input  logic link_fault,
    output logic link_up
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            link_up <= 1'b0;
        else if (link_fault)
            link_up <= 1'b0;
        else
            link_up <= link_bit;
    end
endmodule

// File: rtl/irq_aggregator.sv
module irq_aggregator
    import irq_agg_pkg::*;
#(
    parameter int EVT_W  = 8,
    parameter int SUM_W  = 4,
    parameter int ADDR_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [EVT_W-1:0]  evt_set_hi,
    input  logic [EVT_W-1:0]  evt_set_lo,
    input  logic [SUM_W-1:0]  sum_src,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [EVT_W-1:0]  wr_data,
    input  logic              xact_active,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [EVT_W-1:0]  rd_data,
    input  logic              link_bit,
    input  logic              link_fault,
    output logic              irq,
    output logic              link_up
);
    localparam int PAD_W = EVT_W - SUM_W;

    logic [EVT_W-1:0] evt_hi_q, evt_lo_q, msk_hi_q, msk_lo_q;
    logic [SUM_W-1:0] msk_sum_q;
    logic             sel_ehi, sel_elo, sel_mhi, sel_mlo, sel_msum;
    logic             evt_wr, blanked, pending;

    assign sel_ehi  = wr_en && (wr_addr == ADDR_W'(ADR_EVT_HI));
    assign sel_elo  = wr_en && (wr_addr == ADDR_W'(ADR_EVT_LO));
    assign sel_mhi  = wr_en && (wr_addr == ADDR_W'(ADR_MSK_HI));
    assign sel_mlo  = wr_en && (wr_addr == ADDR_W'(ADR_MSK_LO));
    assign sel_msum = wr_en && (wr_addr == ADDR_W'(ADR_MSK_SUM));
    assign evt_wr   = sel_ehi || sel_elo;

    irq_evt_reg #(.W(EVT_W)) u_evt_hi (
        .clk(clk), .rst_n(rst_n), .set_pulse(evt_set_hi),
        .clr_en(sel_ehi), .clr_bits(wr_data), .q(evt_hi_q));

    irq_evt_reg #(.W(EVT_W)) u_evt_lo (
        .clk(clk), .rst_n(rst_n), .set_pulse(evt_set_lo),
        .clr_en(sel_elo), .clr_bits(wr_data), .q(evt_lo_q));

    irq_mask_reg #(.W(EVT_W)) u_msk_hi (
        .clk(clk), .rst_n(rst_n), .we(sel_mhi), .d(wr_data), .q(msk_hi_q));

    irq_mask_reg #(.W(EVT_W)) u_msk_lo (
        .clk(clk), .rst_n(rst_n), .we(sel_mlo), .d(wr_data), .q(msk_lo_q));

    irq_mask_reg #(.W(SUM_W)) u_msk_sum (
        .clk(clk), .rst_n(rst_n), .we(sel_msum), .d(wr_data[SUM_W-1:0]), .q(msk_sum_q));

    irq_blank_fsm u_blank (
        .clk(clk), .rst_n(rst_n), .xact_active(xact_active),
        .evt_wr(evt_wr), .blanked(blanked));

    irq_link_track u_link (
        .clk(clk), .rst_n(rst_n), .link_bit(link_bit),
        .link_fault(link_fault), .link_up(link_up));

    assign pending = (|(evt_hi_q & msk_hi_q)) || (|(evt_lo_q & msk_lo_q))
                  || (|(sum_src & msk_sum_q));
    assign irq = pending && !blanked;

    always_comb begin
        rd_data = '0;
        if (rd_addr == ADDR_W'(ADR_EVT_HI))       rd_data = evt_hi_q;
        else if (rd_addr == ADDR_W'(ADR_EVT_LO))  rd_data = evt_lo_q;
        else if (rd_addr == ADDR_W'(ADR_MSK_HI))  rd_data = msk_hi_q;
        else if (rd_addr == ADDR_W'(ADR_MSK_LO))  rd_data = msk_lo_q;
        else if (rd_addr == ADDR_W'(ADR_MSK_SUM)) rd_data = {{PAD_W{1'b0}}, msk_sum_q};
    end
endmodule

// File: rtl/irq_aggregator_chk.sv
module irq_aggregator_chk #(
    parameter int EVT_W  = 8,
    parameter int SUM_W  = 4,
    parameter int ADDR_W = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic [EVT_W-1:0]  evt_set_hi,
    input logic              wr_en,
    input logic [ADDR_W-1:0] wr_addr,
    input logic [EVT_W-1:0]  wr_data,
    input logic              xact_active,
    input logic [SUM_W-1:0]  sum_src,
    input logic              link_fault,
    input logic              irq,
    input logic              link_up,
    input logic [EVT_W-1:0]  ev_hi,
    input logic [EVT_W-1:0]  ev_lo,
    input logic [EVT_W-1:0]  mk_hi,
    input logic [EVT_W-1:0]  mk_lo,
    input logic [SUM_W-1:0]  mk_sum
);
    logic xd;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) xd <= 1'b0;
        else        xd <= xact_active;
    end

    logic ev_write;
    assign ev_write = wr_en && (wr_addr == ADDR_W'(0) || wr_addr == ADDR_W'(1));

    AST_SET_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_set_hi != '0) |=> ((ev_hi & $past(evt_set_hi)) == $past(evt_set_hi))); // R2

    AST_W1C_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == ADDR_W'(0)) |=> ((ev_hi & $past(wr_data & ~evt_set_hi)) == '0)); // R3

    AST_IRQ_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (((ev_hi & mk_hi) != '0) || ((ev_lo & mk_lo) != '0) || ((sum_src & mk_sum) != '0))); // R5

    AST_BLANK_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_write && !(xd && !xact_active)) |=> !irq); // R6

    AST_FAULT_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        link_fault |=> !link_up); // R8
endmodule

bind irq_aggregator irq_aggregator_chk #(.EVT_W(EVT_W), .SUM_W(SUM_W), .ADDR_W(ADDR_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .evt_set_hi(evt_set_hi), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .xact_active(xact_active), .sum_src(sum_src), .link_fault(link_fault),
    .irq(irq), .link_up(link_up), .ev_hi(evt_hi_q), .ev_lo(evt_lo_q), .mk_hi(msk_hi_q),
    .mk_lo(msk_lo_q), .mk_sum(msk_sum_q));

// File: tb/tb_irq_aggregator.sv
module tb_irq_aggregator;
    localparam int EVT_W = 8, SUM_W = 4, ADDR_W = 3;

    logic clk = 0, rst_n = 0;
    logic [EVT_W-1:0] evt_set_hi = 0, evt_set_lo = 0, wr_data = 0, rd_data;
    logic [SUM_W-1:0] sum_src = 0;
    logic wr_en = 0, xact_active = 0, link_bit = 0, link_fault = 0, irq, link_up;
    logic [ADDR_W-1:0] wr_addr = 0, rd_addr = 0;

    always #4 clk = ~clk;

    irq_aggregator #(.EVT_W(EVT_W), .SUM_W(SUM_W), .ADDR_W(ADDR_W)) dut (.*);

    // stimulus staged for the next cycle
    logic s_rst = 0, s_wr = 0, s_xact = 0, s_lb = 0, s_lf = 0;
    logic [EVT_W-1:0] s_sh = 0, s_sl = 0, s_wd = 0;
    logic [SUM_W-1:0] s_ss = 0;
    logic [ADDR_W-1:0] s_wa = 0, s_ra = 0;

    // reference state after the latest edge
    logic [EVT_W-1:0] m_eh = 0, m_el = 0, m_mh = 0, m_ml = 0;
    logic [SUM_W-1:0] m_ms = 0;
    logic m_blank = 0, m_xd = 0, m_link = 0;

    int total = 0, bad = 0;

    function automatic logic exp_irq();
        return !m_blank && (((m_eh & m_mh) != 0) || ((m_el & m_ml) != 0) || ((sum_src & m_ms) != 0));
    endfunction

    function automatic logic [EVT_W-1:0] exp_rd(input logic [ADDR_W-1:0] a);
        case (a)
            0: return m_eh;
            1: return m_el;
            2: return m_mh;
            3: return m_ml;
            4: return EVT_W'(m_ms);
            default: return '0;
        endcase
    endfunction

    task automatic chk(input string req, input logic [EVT_W-1:0] act, input logic [EVT_W-1:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h t=%0t", req, act, exp, $time);
        end
    endtask

    task automatic model_step();
        logic fall, evw;
        if (!s_rst) begin
            m_eh = 0; m_el = 0; m_mh = 0; m_ml = 0; m_ms = 0;
            m_blank = 0; m_xd = 0; m_link = 0;
            return;
        end
        fall = m_xd && !s_xact;
        evw  = s_wr && (s_wa == 0 || s_wa == 1);
        m_eh = (m_eh & ~((s_wr && s_wa == 0) ? s_wd : '0)) | s_sh;
        m_el = (m_el & ~((s_wr && s_wa == 1) ? s_wd : '0)) | s_sl;
        if (s_wr && s_wa == 2) m_mh = s_wd;
        if (s_wr && s_wa == 3) m_ml = s_wd;
        if (s_wr && s_wa == 4) m_ms = s_wd[SUM_W-1:0];
        m_blank = fall ? 1'b0 : (m_blank || evw);
        m_xd = s_xact;
        m_link = s_lf ? 1'b0 : s_lb;
    endtask

    // check outputs of the previous edge, then drive the staged inputs
    task automatic tick();
        @(negedge clk);
        if (rst_n) begin
            chk(m_blank ? "R6" : "R5", EVT_W'(irq), EVT_W'(exp_irq()));
            chk("R8", EVT_W'(link_up), EVT_W'(m_link));
            chk(rd_addr < 2 ? "R3" : "R4", rd_data, exp_rd(rd_addr));
        end
        rst_n = s_rst; evt_set_hi = s_sh; evt_set_lo = s_sl; sum_src = s_ss;
        wr_en = s_wr; wr_addr = s_wa; wr_data = s_wd; xact_active = s_xact;
        rd_addr = s_ra; link_bit = s_lb; link_fault = s_lf;
        model_step();
    endtask

    task automatic quiet();
        s_sh = 0; s_sl = 0; s_wr = 0; s_lf = 0;
    endtask

    task automatic wr(input int a, input logic [EVT_W-1:0] d);
        s_wr = 1; s_wa = ADDR_W'(a); s_wd = d; tick(); s_wr = 0;
    endtask

    // settle: one tick so the staged value reaches the edge, one to observe
    task automatic settle();
        quiet(); tick(); tick();
    endtask

    initial begin
        #1_000_000;
        bad++; total++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        void'($urandom(32'h5eed_1234));
        s_rst = 0; tick(); tick();
        s_rst = 1; tick();
        // R1: reset values on every read address
        for (int a = 0; a < 8; a++) begin
            s_ra = ADDR_W'(a); tick(); tick();
            chk("R1", rd_data, '0);
        end
        chk("R1", EVT_W'({irq, link_up}), '0);

        // R2: set pulse, sticky
        wr(2, 8'h10);
        s_sh = 8'h10; tick(); quiet(); tick(); tick(); tick();
        s_ra = 0; tick(); tick();
        chk("R2", rd_data, 8'h10);
        chk("R2", EVT_W'(irq), 1);

        // R3: write-1-clear and set priority on the same bit
        wr(0, 8'h01);
        s_sh = 8'h01; s_wr = 1; s_wa = 0; s_wd = 8'h01; tick(); quiet(); tick();
        chk("R3", rd_data, 8'h11);
        wr(0, 8'h11); tick();
        chk("R3", rd_data, 8'h00);

        // R6: blanking inside a transaction
        wr(3, 8'h04);
        s_sl = 8'h04; tick(); quiet(); tick();
        s_xact = 1; tick();
        wr(1, 8'h00); tick();
        chk("R6", EVT_W'(irq), 0);
        tick(); tick();
        chk("R6", EVT_W'(irq), 0);
        s_xact = 0; tick(); tick();
        chk("R6", EVT_W'(irq), 1);

        // R7: mask write does not blank
        s_xact = 1; tick();
        wr(4, 8'h00); tick();
        chk("R7", EVT_W'(irq), 1);
        s_xact = 0; tick();

        // R9: event write coinciding with transaction end
        s_xact = 1; tick(); tick();
        s_xact = 0; wr(1, 8'h00); tick();
        chk("R9", EVT_W'(irq), 1);

        // R4: unused address ignores writes, reads zero
        wr(5, 8'hff); s_ra = 5; tick(); tick();
        chk("R4", rd_data, '0);

        // R8: link follow and fault priority
        s_lb = 1; tick(); tick();
        chk("R8", EVT_W'(link_up), 1);
        s_lf = 1; tick(); quiet(); tick();
        chk("R8", EVT_W'(link_up), 0);

        // random traffic, checked every cycle in tick()
        for (int i = 0; i < 4000; i++) begin
            quiet();
            if ($urandom_range(0, 7) == 0) s_sh = EVT_W'($urandom & $urandom);
            if ($urandom_range(0, 7) == 0) s_sl = EVT_W'($urandom & $urandom);
            if ($urandom_range(0, 9) == 0) s_ss = SUM_W'($urandom);
            if ($urandom_range(0, 5) == 0) s_xact = !s_xact;
            if ($urandom_range(0, 4) == 0) begin
                s_wr = 1; s_wa = ADDR_W'($urandom_range(0, 7)); s_wd = EVT_W'($urandom);
            end
            if ($urandom_range(0, 15) == 0) s_lb = !s_lb;
            s_lf = ($urandom_range(0, 19) == 0);
            s_ra = ADDR_W'($urandom_range(0, 7));
            tick();
        end
        settle();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule